// File: doc/BRIEF.md
# Shared-Bus Cycle Sequencer for Asynchronous and SDRAM Areas

This block owns one external bus that serves two kinds of target. Plain asynchronous memory areas get a three-state strobe cycle. One area, chosen by parameter, holds a synchronous DRAM, and an access there is issued as a command sequence. The sequencer accepts one request at a time. Each request carries an area number, a write flag and a byte address. The sequencer walks a named state machine, and the bus pins and the state code are decoded directly from that state.

States and codes: IDLE (0), TI idle gap (1), T1 (2), T2 (3), T3 (4), TP precharge (5), TR row activate (6), TC1 column command (7), TCL latency wait (8), TC2 data/last (9). The transitions are as follows. IDLE or a last state goes to TI, T1, TP or TC1 when a request is accepted. TI repeats, then goes to the pending first state. T1 goes to T2, and T2 goes to T3. TP goes to TR, and TR goes to TC1. TC1 goes to TCL for a read and to TC2 for a write. TCL goes to TC2. T3 and TC2 go to IDLE when no request is waiting.

Commands are driven on {ras_n, cas_n, we_n}, all active low: NOP 111, precharge-all 010 (bus address bit 10 high), activate 011, read 101, write 100. Idle gaps between back-to-back accesses follow a 2-bit length and three enable bits. A full DRAM read that follows a read in another area is an exception: it gets only its precharge state and no gap.

Top module: `sdr_seq`

## Requirements
- R1: While reset is low and immediately after it, bus_state is 0 (IDLE), the command is 111, cke is 1, dqm is 11, rd_n is 1, bus_addr is 0 and req_ready is 1.
- R2: A request to any area other than the DRAM area (default area 2) runs T1, T2, T3 with bus_addr equal to the request address. rd_n is low in all three states for a read and high for a write.
- R3: A DRAM read without an open-row hit runs TP (cmd 010, bus_addr = 0x0400), TR (cmd 011, bus_addr = address bits [15:8]), TC1 (cmd 101, bus_addr = address bits [7:0]), TCL (cmd 111) and TC2 (cmd 111), one state per clock.
- R4: A DRAM write without a hit runs TP, TR, TC1 (cmd 100, column address) and TC2 (cmd 111).
- R5: When ras_down_en is 1 and the row last activated is still open and equal to the new DRAM request's row, the access starts at TC1 and skips TP and TR. A different row gets the full sequence.
- R6: req_ready is 1 in IDLE, T3 and TC2 only. A request is taken on an edge where req_valid and req_ready are both 1. A last state with no request returns to IDLE.
- R7: When a gap is due, exactly idle_len TI states (1 to 3) come before the access. idle_len 0 gives none. A gap is only considered for a request taken in T3 or TC2, never for one taken in IDLE.
- R8: A gap is due when the previous access was a read and either idle_sel[0] is set and the area differs, or idle_sel[1] is set and the new access is a write.
- R9: A DRAM read without a hit that follows a read in a different area gets no TI from idle_sel[0]. It goes straight to TP.
- R10: A DRAM hit (R5) that follows a read gets a gap when idle_sel[2] is set.
- R11: dqm is 00 in TC1 and in TCL, and in TC2 of a read if idle_len was non-zero when that read was taken. It is 11 in every other state.
- R12: cke is held at 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_area | input | 3 | Target area number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; for DRAM, row is [15:8] and column is [7:0] |
| idle_len | input | 2 | Number of TI states per gap |
| idle_sel | input | 3 | Gap enables: [0] area change, [1] read-to-write, [2] open-row burst |
| ras_down_en | input | 1 | Keep the DRAM row open between accesses |
| req_ready | output | 1 | Request can be taken on the next edge |
| bus_state | output | 4 | Current state code |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | DRAM clock enable |
| dqm | output | 2 | Upper/lower byte masks, 1 = masked |
| rd_n | output | 1 | Asynchronous read strobe, active low |
| bus_addr | output | 16 | Multiplexed address |

## Verification
The state moves one edge after a request is taken. Every pin is decoded from the state, so it is valid in that same cycle, and each later state follows one edge apart, with TI states counted by idle_len. The bench builds the expected state trace per request stream from the rules above. The stream covers every idle length, three enable patterns, and both row-open settings. The bench advances to the next request only on the falling edge that follows an edge where req_ready was high. It then compares state, command, address, strobes, ready and masks on every falling edge, halfway between the edges that move the state.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_TI   = 4'd1,
        ST_T1   = 4'd2,
        ST_T2   = 4'd3,
        ST_T3   = 4'd4,
        ST_TP   = 4'd5,
        ST_TR   = 4'd6,
        ST_TC1  = 4'd7,
        ST_TCL  = 4'd8,
        ST_TC2  = 4'd9
    } bus_st_e;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_PALL = 3'b010;
    localparam logic [2:0] CMD_ACTV = 3'b011;
    localparam logic [2:0] CMD_READ = 3'b101;
    localparam logic [2:0] CMD_WRIT = 3'b100;

endpackage

// File: rtl/sdr_row_track.sv
module sdr_row_track
    import sdr_seq_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_st_e          st,
    input  logic             ras_down_en,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [ROW_W-1:0] new_row,
    output logic             row_hit
);

    logic             row_open;
    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (st == ST_TP) begin
            row_open <= 1'b0;
        end else if (st == ST_TR) begin
            row_open <= 1'b1;
            open_row <= cur_row;
        end
    end

    assign row_hit = ras_down_en && row_open && (open_row == new_row);

endmodule

// File: rtl/sdr_idle_ctl.sv
module sdr_idle_ctl
    import sdr_seq_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int LEN_W  = 2
) (
    input  logic              back_to_back,
    input  logic              prev_write,
    input  logic [AREA_W-1:0] prev_area,
    input  logic [AREA_W-1:0] new_area,
    input  logic              new_write,
    input  logic              new_dram,
    input  logic              new_hit,
    input  logic [LEN_W-1:0]  idle_len,
    input  logic [2:0]        idle_sel,
    output logic              idle_need,
    output bus_st_e           first_st
);

    logic area_change;
    logic full_dram_read;
    logic by_area, by_write, by_burst;

    assign area_change    = (prev_area != new_area);
    assign full_dram_read = new_dram && !new_hit && !new_write;

    // a full DRAM read after a read elsewhere takes only its precharge state
    assign by_area  = idle_sel[0] && area_change && !full_dram_read;
    assign by_write = idle_sel[1] && new_write;
    assign by_burst = idle_sel[2] && new_hit;

    assign idle_need = back_to_back && !prev_write && (idle_len != '0)
                       && (by_area || by_write || by_burst);

    always_comb begin
        if (!new_dram)    first_st = ST_T1;
        else if (new_hit) first_st = ST_TC1;
        else              first_st = ST_TP;
    end

endmodule

// File: rtl/sdr_cmd_dec.sv
module sdr_cmd_dec
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COL_W  = 8
) (
    input  bus_st_e           st,
    input  logic              cur_write,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_mask_ext,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        dqm,
    output logic              rd_n,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam int A10   = 10;
    localparam int ROW_W = ADDR_W - COL_W;

    logic [2:0]        cmd;
    logic [ADDR_W-1:0] row_addr, col_addr;

    assign row_addr = ADDR_W'(cur_addr[ADDR_W-1:COL_W]);
    assign col_addr = ADDR_W'(cur_addr[COL_W-1:0]);

    always_comb begin
        cmd      = CMD_NOP;
        dqm      = 2'b11;
        rd_n     = 1'b1;
        bus_addr = '0;
        unique case (st)
            ST_T1, ST_T2, ST_T3: begin
                rd_n     = cur_write;
                bus_addr = cur_addr;
            end
            ST_TP: begin
                cmd           = CMD_PALL;
                bus_addr[A10] = 1'b1;
            end
            ST_TR: begin
                cmd      = CMD_ACTV;
                bus_addr = row_addr;
            end
            ST_TC1: begin
                cmd      = cur_write ? CMD_WRIT : CMD_READ;
                bus_addr = col_addr;
                dqm      = 2'b00;
            end
            ST_TCL: begin
                bus_addr = col_addr;
                dqm      = 2'b00;
            end
            ST_TC2: begin
                bus_addr = col_addr;
                dqm      = (!cur_write && cur_mask_ext) ? 2'b00 : 2'b11;
            end
            default: ;
        endcase
    end

    assign {ras_n, cas_n, we_n} = cmd;

    if (ROW_W < 1) begin : g_bad_split
        initial $error("COL_W must be below ADDR_W");
    end

endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int COL_W     = 8,
    parameter int AREA_W    = 3,
    parameter int DRAM_AREA = 2,
    parameter int LEN_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  idle_len,
    input  logic [2:0]        idle_sel,
    input  logic              ras_down_en,
    output logic              req_ready,
    output logic [3:0]        bus_state,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cke,
    output logic [1:0]        dqm,
    output logic              rd_n,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam int ROW_W = ADDR_W - COL_W;

    bus_st_e           st, st_nx, pend_first, first_st, start_st;
    logic [LEN_W-1:0]  ti_cnt;
    logic [AREA_W-1:0] cur_area;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_mask_ext;
    logic              b2b, accept, req_dram, row_hit, dram_hit, idle_need;

    assign req_dram  = (req_area == AREA_W'(DRAM_AREA));
    assign b2b       = (st == ST_T3) || (st == ST_TC2);
    assign req_ready = (st == ST_IDLE) || b2b;
    assign accept    = req_valid && req_ready;
    assign dram_hit  = req_dram && row_hit;
    assign start_st  = idle_need ? ST_TI : first_st;

    sdr_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (st),
        .ras_down_en (ras_down_en),
        .cur_row     (cur_addr[ADDR_W-1:COL_W]),
        .new_row     (req_addr[ADDR_W-1:COL_W]),
        .row_hit     (row_hit)
    );

    sdr_idle_ctl #(.AREA_W(AREA_W), .LEN_W(LEN_W)) u_idle (
        .back_to_back (b2b),
        .prev_write   (cur_write),
        .prev_area    (cur_area),
        .new_area     (req_area),
        .new_write    (req_write),
        .new_dram     (req_dram),
        .new_hit      (dram_hit),
        .idle_len     (idle_len),
        .idle_sel     (idle_sel),
        .idle_need    (idle_need),
        .first_st     (first_st)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) st_nx = first_st;
            ST_TI:   st_nx = (ti_cnt == LEN_W'(1)) ? pend_first : ST_TI;
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ST_T3;
            ST_TP:   st_nx = ST_TR;
            ST_TR:   st_nx = ST_TC1;
            ST_TC1:  st_nx = cur_write ? ST_TC2 : ST_TCL;
            ST_TCL:  st_nx = ST_TC2;
            ST_T3, ST_TC2: st_nx = accept ? start_st : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            ti_cnt       <= '0;
            pend_first   <= ST_IDLE;
            cur_area     <= '0;
            cur_write    <= 1'b0;
            cur_addr     <= '0;
            cur_mask_ext <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                ti_cnt       <= idle_len;
                pend_first   <= first_st;
                cur_area     <= req_area;
                cur_write    <= req_write;
                cur_addr     <= req_addr;
                cur_mask_ext <= (idle_len != '0);
            end else if (st == ST_TI) begin
                ti_cnt <= ti_cnt - LEN_W'(1);
            end
        end
    end

    sdr_cmd_dec #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dec (
        .st           (st),
        .cur_write    (cur_write),
        .cur_addr     (cur_addr),
        .cur_mask_ext (cur_mask_ext),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .dqm          (dqm),
        .rd_n         (rd_n),
        .bus_addr     (bus_addr)
    );

    assign bus_state = st;
    assign cke       = 1'b1;

endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        bus_state,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              cke,
    input logic [1:0]        dqm,
    input logic              rd_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              req_ready,
    input logic              cur_write
);

    // R12
    cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cke == 1'b1);

    // R3
    tp_to_tr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_TP |=> bus_state == ST_TR);

    // R3
    tr_to_tc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_TR |=> bus_state == ST_TC1);

    // R3
    rd_tc1_tcl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_TC1 && !cur_write) |=> bus_state == ST_TCL);

    // R3
    tcl_to_tc2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_TCL |=> bus_state == ST_TC2);

    // R2
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_T1 |=> bus_state == ST_T2);

    // R2
    t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_T2 |=> bus_state == ST_T3);

    // R3
    pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && cas_n && !we_n) |-> bus_addr[10]);

    // R2
    rd_only_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (bus_state inside {ST_T1, ST_T2, ST_T3}));

    // R6
    no_ready_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_state == ST_TI |-> !req_ready);

    // R7
    gap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_state == ST_TI) |-> ($past(bus_state) inside {ST_T3, ST_TC2}));

    // R11
    mask_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state inside {ST_IDLE, ST_TI, ST_T1, ST_T2, ST_T3, ST_TP, ST_TR}) |-> dqm == 2'b11);

endmodule

bind sdr_seq sdr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_state (bus_state),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cke       (cke),
    .dqm       (dqm),
    .rd_n      (rd_n),
    .bus_addr  (bus_addr),
    .req_ready (req_ready),
    .cur_write (cur_write)
);

// File: tb/sdr_seq_tb.sv
`timescale 1ns/1ps
module sdr_seq_tb;

    localparam int NREQ = 16;
    localparam int EMAX = 160;

    // {area[2:0], write, addr[15:0]}; DRAM area is 2
    localparam logic [19:0] REQS [NREQ] = '{
        {3'd2, 1'b0, 16'h1234}, {3'd2, 1'b0, 16'h1256}, {3'd0, 1'b0, 16'h0040},
        {3'd2, 1'b0, 16'h3410}, {3'd2, 1'b1, 16'h3420}, {3'd1, 1'b1, 16'h0100},
        {3'd1, 1'b0, 16'h0104}, {3'd1, 1'b1, 16'h0108}, {3'd2, 1'b0, 16'h5501},
        {3'd0, 1'b0, 16'h0200}, {3'd2, 1'b0, 16'h5502}, {3'd2, 1'b0, 16'h6600},
        {3'd0, 1'b1, 16'h0300}, {3'd0, 1'b0, 16'h0304}, {3'd3, 1'b0, 16'h0400},
        {3'd2, 1'b1, 16'h6610}
    };
    localparam logic [2:0] SELS [3] = '{3'b111, 3'b001, 3'b110};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_area = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  idle_len = '0;
    logic [2:0]  idle_sel = '0;
    logic        ras_down_en = 1'b0;
    logic        req_ready, ras_n, cas_n, we_n, cke, rd_n;
    logic [3:0]  bus_state;
    logic [1:0]  dqm;
    logic [15:0] bus_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0] exp_st [EMAX];
    int         exp_rq [EMAX];
    string      exp_tag [EMAX];
    int         n_exp;

    always #2.5 clk = ~clk;

    sdr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_area(req_area),
        .req_write(req_write), .req_addr(req_addr), .idle_len(idle_len),
        .idle_sel(idle_sel), .ras_down_en(ras_down_en), .req_ready(req_ready),
        .bus_state(bus_state), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .dqm(dqm), .rd_n(rd_n), .bus_addr(bus_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string state_tag(input logic [3:0] s, input logic w);
        case (s)
            4'd0: return "R6";
            4'd1: return "R7";
            4'd2, 4'd3, 4'd4: return "R2";
            default: return w ? "R4" : "R3";
        endcase
    endfunction

    // {cmd[2:0], cke, rd_n, addr[15:0], ready}; R12 cke expected 1 in all states
    function automatic logic [21:0] exp_pins(input logic [3:0] s, input logic [19:0] r);
        logic [2:0] cmd = 3'b111;
        logic rd = 1'b1, rdy = 1'b0;
        logic [15:0] a = 16'h0;
        case (s)
            4'd0: rdy = 1'b1;
            4'd2, 4'd3: begin rd = r[16]; a = r[15:0]; end
            4'd4: begin rd = r[16]; a = r[15:0]; rdy = 1'b1; end
            4'd5: begin cmd = 3'b010; a = 16'h0400; end
            4'd6: begin cmd = 3'b011; a = {8'h00, r[15:8]}; end
            4'd7: begin cmd = r[16] ? 3'b100 : 3'b101; a = {8'h00, r[7:0]}; end
            4'd8: a = {8'h00, r[7:0]};
            4'd9: begin a = {8'h00, r[7:0]}; rdy = 1'b1; end
            default: ;
        endcase
        return {cmd, 1'b1, rd, a, rdy};
    endfunction

    function automatic logic [1:0] exp_mask(input logic [3:0] s, input logic [19:0] r, input logic [1:0] len);
        if (s == 4'd7 || s == 4'd8) return 2'b00;
        if (s == 4'd9 && !r[16] && len != 2'd0) return 2'b00;
        return 2'b11;
    endfunction

    task automatic push(input logic [3:0] s, input int rq, input string tag);
        exp_st[n_exp] = s; exp_rq[n_exp] = rq; exp_tag[n_exp] = tag;
        n_exp++;
    endtask

    task automatic build_model(input logic [1:0] len, input logic [2:0] sel, input logic ras);
        bit open = 1'b0;
        logic [7:0] orow = '0;
        n_exp = 0;
        for (int i = 0; i < NREQ; i++) begin
            logic [19:0] r = REQS[i];
            bit dram = (r[19:17] == 3'd2);
            bit wr = r[16];
            bit hit = dram && ras && open && (orow == r[15:8]);
            bit need = 1'b0;
            bit exc = 1'b0;
            string first_tag = "";
            if (i > 0) begin
                logic [19:0] p = REQS[i-1];
                bit diff = (p[19:17] != r[19:17]);
                bit full_rd = dram && !hit && !wr;
                need = !p[16] && (len != 2'd0) &&
                       ((sel[1] && wr) || (sel[0] && diff && !full_rd) || (sel[2] && hit));
                exc = !p[16] && diff && full_rd && sel[0] && (len != 2'd0);
            end
            if (need) for (int k = 0; k < int'(len); k++) push(4'd1, i, "R7 R8 R10");
            if (exc) first_tag = "R9";
            else if (hit) first_tag = "R5";
            if (!dram) begin
                push(4'd2, i, first_tag == "" ? "R2" : first_tag);
                push(4'd3, i, "R2");
                push(4'd4, i, "R2");
            end else begin
                if (!hit) begin
                    push(4'd5, i, first_tag == "" ? (wr ? "R4" : "R3") : first_tag);
                    push(4'd6, i, wr ? "R4" : "R3");
                    open = 1'b1;
                    orow = r[15:8];
                    push(4'd7, i, wr ? "R4" : "R3");
                end else begin
                    push(4'd7, i, first_tag);
                end
                if (!wr) push(4'd8, i, "R3");
                push(4'd9, i, wr ? "R4" : "R3");
            end
        end
        push(4'd0, 0, "R6");
    endtask

    task automatic drive_req(input int idx);
        if (idx < NREQ) begin
            req_valid = 1'b1;
            {req_area, req_write, req_addr} = REQS[idx];
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic run_stream(input logic [1:0] len, input logic [2:0] sel, input logic ras);
        int idx = 0;
        bit prev_rdy = 1'b1;
        idle_len = len; idle_sel = sel; ras_down_en = ras;
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        build_model(len, sel, ras);
        rst_n = 1'b1;
        drive_req(0);
        for (int c = 0; c < n_exp; c++) begin
            logic [19:0] r;
            @(negedge clk);
            r = REQS[exp_rq[c]];
            check(bus_state == exp_st[c], exp_tag[c], 32'(bus_state), 32'(exp_st[c]));
            check({ras_n, cas_n, we_n, cke, rd_n, bus_addr, req_ready} == exp_pins(exp_st[c], r),
                  state_tag(exp_st[c], r[16]),
                  32'({ras_n, cas_n, we_n, cke, rd_n, bus_addr, req_ready}),
                  32'(exp_pins(exp_st[c], r)));
            check(dqm == exp_mask(exp_st[c], r, len), "R11", 32'(dqm), 32'(exp_mask(exp_st[c], r, len)));
            if (prev_rdy && req_valid) begin
                idx++;
                drive_req(idx);
            end
            prev_rdy = req_ready;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and right after reset
        repeat (2) @(negedge clk);
        check({bus_state, ras_n, cas_n, we_n, cke, dqm, rd_n, bus_addr, req_ready} ==
              {4'd0, 3'b111, 1'b1, 2'b11, 1'b1, 16'h0, 1'b1}, "R1",
              32'({bus_state, ras_n, cas_n, we_n, cke, dqm, rd_n, bus_addr, req_ready}),
              32'({4'd0, 3'b111, 1'b1, 2'b11, 1'b1, 16'h0, 1'b1}));
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_state == 4'd0 && req_ready && dqm == 2'b11 && cke, "R1",
              32'(bus_state), 32'd0);

        // Table-driven streams over all idle lengths, enable patterns, row modes
        for (int len = 0; len < 4; len++)
            for (int s = 0; s < 3; s++)
                for (int ras = 0; ras < 2; ras++)
                    run_stream(2'(len), SELS[s], 1'(ras));

        // R7: a request taken in IDLE never gets a gap
        rst_n = 1'b0;
        idle_len = 2'd3; idle_sel = 3'b111; ras_down_en = 1'b0;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_area = 3'd0; req_write = 1'b0; req_addr = 16'h0010;
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_state == 4'd2, "R2", 32'(bus_state), 32'd2);
        repeat (2) @(negedge clk);
        check(bus_state == 4'd4 && !rd_n, "R2", 32'({bus_state, rd_n}), 32'({4'd4, 1'b0}));
        @(negedge clk);
        check(bus_state == 4'd0 && req_ready, "R6", 32'(bus_state), 32'd0);
        req_valid = 1'b1; req_area = 3'd1; req_write = 1'b1; req_addr = 16'h0020;
        @(negedge clk);
        req_valid = 1'b0;
        check(bus_state == 4'd2 && rd_n && bus_addr == 16'h0020, "R7",
              32'({bus_state, rd_n, bus_addr}), 32'({4'd2, 1'b1, 16'h0020}));

        // R12: cke after the whole run
        check(cke == 1'b1, "R12", 32'(cke), 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule